// File: doc/BRIEF.md
# Misaligned Halfword Register Bus Adapter

This block sits on the slave side of a narrow register bus. It gives a master that issues byte or halfword transfers access to an internal bank of 16-bit registers. Each register occupies one even address and the odd address after it, in big-endian order. The even address holds the upper half, called byte 0. The odd address holds the lower half, called byte 1. Byte writes touch only the addressed lane. Every read returns the full location, and the master picks out the lane it wants.

A halfword transfer at an odd address crosses two locations. The adapter splits it into two bank cycles that run back to back. The first cycle handles byte 1 of location N. The second handles byte 0 of location N+1, and the location index wraps from the last one to 0.

The request side follows valid/ready rules. A transfer is accepted on a rising edge where `req_valid` and `req_ready` are both high. The master must hold its request stable until that edge. `req_ready` drops for exactly one cycle, the cycle after a split transfer is accepted, and nothing is taken in that cycle. The response is a one-cycle `rsp_done` strobe with `rsp_rdata`. The response cannot be back-pressured.

Top module: `halfword_reg_adapter`

## Requirements
- R1: After reset, all 8 locations read as 0000h, `req_ready` is high and `rsp_done` is low.
- R2: A byte write (size 01) to an even address loads `req_wdata[15:8]` into byte 0 of the location and leaves byte 1 unchanged.
- R3: A byte write to an odd address loads `req_wdata[7:0]` into byte 1 of the location and leaves byte 0 unchanged.
- R4: A read of any kind that is not split returns the whole location `{byte0, byte1}` on `rsp_rdata`. This includes byte reads at either lane.
- R5: A halfword access (size 10) at an even address reads or writes both bytes of one location in a single bank cycle.
- R6: A halfword read at an odd address of location N returns `{byte1 of N, byte0 of N+1}`.
- R7: A halfword write at an odd address puts `req_wdata[15:8]` into byte 1 of N and `req_wdata[7:0]` into byte 0 of N+1. No other byte changes.
- R8: For an access that is not split, `rsp_done` is high in the cycle after acceptance. For a split access it is low in that cycle and high in the next one, so it pulses exactly once per access.
- R9: `req_ready` is low in the cycle after a split is accepted. A request presented in that cycle is not taken and changes nothing.
- R10: A halfword access at the odd address of the last location uses location 0 as its second location.
- R11: Size codes 00 and 11 complete in one cycle like a single access. They write nothing, and a read returns the whole location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter can take a request this cycle |
| req_size | input | 2 | 01 byte, 10 halfword, others do nothing |
| req_addr | input | log2(N_LOC)+1 | Byte address; bit 0 selects the lane |
| req_we | input | 1 | 1 write, 0 read |
| req_wdata | input | 16 | Write data; the even lane is [15:8] and the odd lane is [7:0] |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read result, valid while rsp_done is high |

## Verification
The bench targets the split path in three ways:
- It checks lane order, so a design that swapped the two bytes of an odd halfword would return or store them reversed.
- It uses the last location, so a missing wrap would fall off the bank instead of reaching location 0.
- It counts strobes, so an early or doubled done pulse would be caught as a timing miscompare or a response nobody asked for.

It holds a foreign request valid during the busy cycle and then reads the target back. A design that took that request would show a corrupted location. Byte writes at both lanes, and the two unused size codes, are read back to catch any write to a lane that should have been left alone.

// File: rtl/rbadp_pkg.sv
package rbadp_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_HALF = 2'b10;

  typedef enum logic {
    ST_IDLE,
    ST_SPLIT
  } seq_st_e;
endpackage

// File: rtl/rbadp_regbank.sv
module rbadp_regbank #(
  parameter int N_LOC = 8,
  localparam int IDX_W = $clog2(N_LOC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       be,     // be[1] = byte 0 (upper), be[0] = byte 1 (lower)
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata
);
  logic [15:0] loc_q [N_LOC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_LOC; i++) loc_q[i] <= '0;
    end else if (wr_en) begin
      if (be[1]) loc_q[idx][15:8] <= wdata[15:8];
      if (be[0]) loc_q[idx][7:0]  <= wdata[7:0];
    end
  end

  assign rdata = loc_q[idx];

  // R2: an upper-lane-only write keeps the lower byte of that location
  a_r2_lower_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && be == 2'b10) |=> loc_q[$past(idx)][7:0] == $past(loc_q[idx][7:0]));

  // R3: a lower-lane-only write keeps the upper byte of that location
  a_r3_upper_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && be == 2'b01) |=> loc_q[$past(idx)][15:8] == $past(loc_q[idx][15:8]));
endmodule

// File: rtl/rbadp_seq.sv
module rbadp_seq
  import rbadp_pkg::*;
#(
  parameter int N_LOC = 8,
  localparam int IDX_W  = $clog2(N_LOC),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic              bank_wr,
  output logic [IDX_W-1:0]  bank_idx,
  output logic [1:0]        bank_be,
  output logic [15:0]       bank_wdata,
  input  logic [15:0]       bank_rdata
);
  seq_st_e          st_q;
  logic [IDX_W-1:0] nxt_idx_q;
  logic             hold_we_q;
  logic [7:0]       hold_lo_q;
  logic [7:0]       hold_hi_q;

  logic accept, lane_odd, is_byte, is_half, split;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign lane_odd  = req_addr[0];
  assign is_byte   = (req_size == SZ_BYTE);
  assign is_half   = (req_size == SZ_HALF);
  assign split     = is_half && lane_odd;

  always_comb begin
    if (st_q == ST_SPLIT) begin
      bank_idx   = nxt_idx_q;
      bank_be    = 2'b10;
      bank_wdata = {hold_lo_q, 8'h00};
      bank_wr    = hold_we_q;
    end else begin
      bank_idx = req_addr[ADDR_W-1:1];
      if (is_byte)      bank_be = lane_odd ? 2'b01 : 2'b10;
      else if (is_half) bank_be = lane_odd ? 2'b01 : 2'b11;
      else              bank_be = 2'b00;
      bank_wdata = split ? {8'h00, req_wdata[15:8]} : req_wdata;
      bank_wr    = accept && req_we && (bank_be != 2'b00);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      nxt_idx_q <= '0;
      hold_we_q <= 1'b0;
      hold_lo_q <= '0;
      hold_hi_q <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          if (split) begin
            st_q      <= ST_SPLIT;
            nxt_idx_q <= bank_idx + IDX_W'(1);
            hold_we_q <= req_we;
            hold_lo_q <= req_wdata[7:0];
            hold_hi_q <= bank_rdata[7:0];
          end else begin
            rsp_done  <= 1'b1;
            rsp_rdata <= bank_rdata;
          end
        end
        ST_SPLIT: begin
          st_q      <= ST_IDLE;
          rsp_done  <= 1'b1;
          rsp_rdata <= {hold_hi_q, bank_rdata[15:8]};
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R8: single-cycle accesses finish on the next cycle
  a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !split) |=> rsp_done);

  // R8: a split gives no strobe after its first half, one after its second
  a_r8_split_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && split) |=> !rsp_done);
  a_r8_split_done: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && split) |=> ##1 rsp_done);

  // R9: busy for the second half of a split
  a_r9_busy_after_split: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && split) |=> !req_ready);

  // R10: the second half lands on the next location, modulo the bank size
  a_r10_next_loc: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && split) |=> bank_idx == $past(req_addr[ADDR_W-1:1]) + IDX_W'(1));
endmodule

// File: rtl/halfword_reg_adapter.sv
module halfword_reg_adapter #(
  parameter int N_LOC = 8,
  localparam int IDX_W  = $clog2(N_LOC),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata
);
  logic             bank_wr;
  logic [IDX_W-1:0] bank_idx;
  logic [1:0]       bank_be;
  logic [15:0]      bank_wdata;
  logic [15:0]      bank_rdata;

  rbadp_seq #(.N_LOC(N_LOC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_size   (req_size),
    .req_addr   (req_addr),
    .req_we     (req_we),
    .req_wdata  (req_wdata),
    .rsp_done   (rsp_done),
    .rsp_rdata  (rsp_rdata),
    .bank_wr    (bank_wr),
    .bank_idx   (bank_idx),
    .bank_be    (bank_be),
    .bank_wdata (bank_wdata),
    .bank_rdata (bank_rdata)
  );

  rbadp_regbank #(.N_LOC(N_LOC)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bank_wr),
    .idx   (bank_idx),
    .be    (bank_be),
    .wdata (bank_wdata),
    .rdata (bank_rdata)
  );

  // R1: idle and quiet right out of reset
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_ready && !rsp_done));
endmodule

// File: tb/test_halfword_reg_adapter.sv
module test_halfword_reg_adapter;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_size = 2'b00;
  logic [3:0]  req_addr = '0;
  logic        req_we = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfword_reg_adapter #(.N_LOC(NL)) i_halfword_reg_adapter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_addr(req_addr), .req_we(req_we),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  typedef struct { logic rd; logic [15:0] data; string tag; } exp_t;
  exp_t        sb_q[$];
  logic [15:0] model [NL];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          ended = 1'b0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: pop expected items as responses appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_done) begin
        if (sb_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R8 actual unexpected done expected none");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (e.rd) chk(e.tag, rsp_rdata, e.data);
        end
      end
    end
  end

  // driver; when stall_other is set, a byte write to addr 12 is held valid in the busy cycle
  task automatic do_acc(input logic [1:0] sz, input logic [3:0] a, input logic w,
                        input logic [15:0] d, input string tag, input bit stall_other);
    logic [2:0] idx, nx;
    logic       spl;
    exp_t       e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    idx = a[3:1];
    nx  = idx + 3'd1;
    spl = (sz == 2'b10) && a[0];
    e.rd = !w;
    e.tag = tag;
    e.data = spl ? {model[idx][7:0], model[nx][15:8]} : model[idx];
    sb_q.push_back(e);
    if (w) begin
      if (sz == 2'b01 && !a[0]) model[idx][15:8] = d[15:8];
      else if (sz == 2'b01 && a[0]) model[idx][7:0] = d[7:0];
      else if (sz == 2'b10 && !a[0]) model[idx] = d;
      else if (spl) begin
        model[idx][7:0] = d[15:8];
        model[nx][15:8] = d[7:0];
      end
    end
    req_size = sz; req_addr = a; req_we = w; req_wdata = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (spl) begin
      chk("R8 split first-half done", {15'd0, rsp_done}, 16'd0);
      chk("R9 busy during split", {15'd0, req_ready}, 16'd0);
      if (stall_other) begin
        req_size = 2'b01; req_addr = 4'd12; req_we = 1'b1; req_wdata = 16'hEEEE;
      end else req_valid = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 split done", {15'd0, rsp_done}, 16'd1);
    end else begin
      req_valid = 1'b0;
      chk("R8 single done", {15'd0, rsp_done}, 16'd1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual hung expected finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NL; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {15'd0, req_ready}, 16'd1);
    chk("R1 done low after reset", {15'd0, rsp_done}, 16'd0);
    for (int i = 0; i < NL; i++) do_acc(2'b10, 4'(2*i), 1'b0, '0, "R1 reset contents", 1'b0);

    // R5 aligned halfword
    do_acc(2'b10, 4'd0, 1'b1, 16'hA1B2, "R5 write", 1'b0);
    do_acc(2'b10, 4'd0, 1'b0, '0, "R5 aligned read", 1'b0);
    // R2 / R3 / R4 byte lanes
    do_acc(2'b01, 4'd2, 1'b1, 16'h3C99, "R2 write", 1'b0);
    do_acc(2'b01, 4'd3, 1'b1, 16'h77D4, "R3 write", 1'b0);
    do_acc(2'b01, 4'd3, 1'b0, '0, "R4 odd byte read", 1'b0);
    do_acc(2'b01, 4'd2, 1'b0, '0, "R4 even byte read", 1'b0);
    do_acc(2'b01, 4'd0, 1'b1, 16'h5511, "R2 write", 1'b0);
    do_acc(2'b10, 4'd0, 1'b0, '0, "R2 byte1 kept", 1'b0);
    do_acc(2'b01, 4'd1, 1'b1, 16'h2266, "R3 write", 1'b0);
    do_acc(2'b10, 4'd0, 1'b0, '0, "R3 byte0 kept", 1'b0);
    // R6 / R7 split
    do_acc(2'b10, 4'd4, 1'b1, 16'h1234, "R5 write", 1'b0);
    do_acc(2'b10, 4'd6, 1'b1, 16'h5678, "R5 write", 1'b0);
    do_acc(2'b10, 4'd5, 1'b0, '0, "R6 odd halfword read", 1'b0);
    do_acc(2'b10, 4'd5, 1'b1, 16'hABCD, "R7 write", 1'b0);
    do_acc(2'b10, 4'd4, 1'b0, '0, "R7 location N", 1'b0);
    do_acc(2'b10, 4'd6, 1'b0, '0, "R7 location N+1", 1'b0);
    do_acc(2'b10, 4'd2, 1'b0, '0, "R7 neighbour untouched", 1'b0);
    do_acc(2'b10, 4'd8, 1'b0, '0, "R7 neighbour untouched", 1'b0);
    // R10 wrap
    do_acc(2'b10, 4'd14, 1'b1, 16'h9F8E, "R5 write", 1'b0);
    do_acc(2'b10, 4'd15, 1'b0, '0, "R10 wrap read", 1'b0);
    do_acc(2'b10, 4'd15, 1'b1, 16'h0102, "R10 write", 1'b0);
    do_acc(2'b10, 4'd14, 1'b0, '0, "R10 last location", 1'b0);
    do_acc(2'b10, 4'd0, 1'b0, '0, "R10 location 0", 1'b0);
    // R9 request held during busy cycle is dropped
    do_acc(2'b10, 4'd9, 1'b1, 16'h4455, "R9 write", 1'b1);
    do_acc(2'b10, 4'd12, 1'b0, '0, "R9 stalled request ignored", 1'b0);
    do_acc(2'b10, 4'd8, 1'b0, '0, "R7 location N", 1'b0);
    do_acc(2'b10, 4'd10, 1'b0, '0, "R7 location N+1", 1'b0);
    // R11 unused size codes
    do_acc(2'b00, 4'd4, 1'b1, 16'hFFFF, "R11 write", 1'b0);
    do_acc(2'b11, 4'd5, 1'b1, 16'hFFFF, "R11 write", 1'b0);
    do_acc(2'b11, 4'd4, 1'b0, '0, "R11 no write, full read", 1'b0);
    do_acc(2'b00, 4'd5, 1'b0, '0, "R11 no write, full read", 1'b0);

    repeat (3) @(negedge clk);
    chk("R8 no stray responses", 16'(sb_q.size()), 16'd0);
    finish_run();
  end
endmodule